// File: doc/BRIEF.md
# GPIO Interrupt and Wake Detector

This block holds the per-pin interrupt logic of a banked GPIO controller. It receives pin levels that have already been synchronised, and it is configured through a simple 32-bit register write/read bus. Each pin can trigger on a rising edge, a falling edge, or both. It can instead trigger on a level, with a selectable active polarity. A detection sets a sticky pending bit for the pin. Software acknowledges that bit by writing a one to it.

Pending bits that are also enabled by their mask bit are combined across all banks into one interrupt line for the parent controller. The same detections can set a separate set of sticky wake-status bits, gated by a per-pin wake enable. All wake-status bits are combined into a single wake output. Each register kind is banked at 32 pins per word. Consecutive banks sit 4 bytes apart.

Top module: `gpio_irq_wake`

## Requirements
- R1: After reset every register reads zero, and `irq_out` and `wake_out` are low.
- R2: Register bases are fixed. Bank b of each kind is at base + 4*b:
  - rising enable 0x064
  - falling enable 0x07C
  - mask 0x0AC
  - source 0x0C4
  - trigger type 0x300
  - polarity 0x318
  - wake enable 0x400
  - wake source 0x418

  Configuration registers read back the last written word. Any other address reads zero.
- R3: With the trigger-type bit 0 and the rising-enable bit 1, a low-to-high change of the pin sets its source bit on the next clock edge. A pin that does not change sets nothing.
- R4: With the trigger-type bit 0 and the falling-enable bit 1, a high-to-low change sets the source bit. With both enables set, either direction sets it.
- R5: With the trigger-type bit 1, the pin triggers on its level. A polarity bit of 0 makes a high level active; a polarity bit of 1 makes a low level active.
- R6: For a level-triggered pin, the source bit is set again on every cycle in which the active level is present. A clear therefore does not stick while the level remains.
- R7: Writing a word to the source register clears each bit written as 1. Bits written as 0 keep their value.
- R8: A detection and a clearing write to the same source bit in the same cycle leave the bit set.
- R9: `irq_out` is high exactly when some pin in any bank has both its source bit and its mask bit equal to 1.
- R10: A detection also sets the pin's wake-status bit when its wake-enable bit is 1. Wake-status bits clear the same way as source bits (a written 1 clears). `wake_out` is the OR of all wake-status bits.
- R11: A source bit, once set, stays set after the pin returns to its idle level, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Synchronised pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined interrupt of enabled pending pins |
| wake_out | output | 1 | Combined wake status |

## Verification
The assertions check four properties on every cycle:
- a detection always wins over a clear in the same cycle;
- a bit written as 1 with no detection is cleared;
- source bits never fall without a clear;
- wake-status bits only rise for pins whose wake enable is set.

They also check that an edge-type pin with no change produces no event. Only the bench scenarios can show the following:
- each trigger mode and polarity responds to the right pin transitions;
- a level source re-asserts after a clear;
- the register offsets and bank stride are decoded correctly;
- a pin in the second bank reaches the shared interrupt line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BANK_W = 32;

    typedef struct packed {
        logic [BANK_W-1:0] rise;
        logic [BANK_W-1:0] fall;
        logic [BANK_W-1:0] mask;
        logic [BANK_W-1:0] itype;
        logic [BANK_W-1:0] pol;
        logic [BANK_W-1:0] wmask;
    } bank_cfg_t;

    typedef struct packed {
        bank_cfg_t         cfg;
        logic [BANK_W-1:0] src;
        logic [BANK_W-1:0] wsrc;
        logic [BANK_W-1:0] prev;
    } bank_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic mask;
        logic src;
        logic itype;
        logic pol;
        logic wmask;
        logic wsrc;
    } bank_wr_t;

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] pin,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] itype,
    input  logic [W-1:0] pol,
    output logic [W-1:0] evt
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic up_w;
        logic dn_w;

        assign up_w = pin[i] & ~prev[i];
        assign dn_w = ~pin[i] & prev[i];

        // Level mode: the polarity bit inverts which level is active.
        assign evt[i] = itype[i] ? (pin[i] ^ pol[i])
                                 : ((rise[i] & up_w) | (fall[i] & dn_w));
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] pin,
    input  bank_wr_t          wr,
    input  logic [BANK_W-1:0] wdata,
    output bank_cfg_t         cfg,
    output logic [BANK_W-1:0] src,
    output logic [BANK_W-1:0] wsrc,
    output logic              irq,
    output logic              wake
);

    bank_state_t       st_d, st_q;
    logic [BANK_W-1:0] evt;
    logic [BANK_W-1:0] clr_src;
    logic [BANK_W-1:0] clr_wsrc;

    gpio_irq_detect #(.W(BANK_W)) u_detect (
        .pin   (pin),
        .prev  (st_q.prev),
        .rise  (st_q.cfg.rise),
        .fall  (st_q.cfg.fall),
        .itype (st_q.cfg.itype),
        .pol   (st_q.cfg.pol),
        .evt   (evt)
    );

    assign clr_src  = wr.src  ? wdata : '0;
    assign clr_wsrc = wr.wsrc ? wdata : '0;

    always_comb begin
        st_d = st_q;
        if (wr.rise)  st_d.cfg.rise  = wdata;
        if (wr.fall)  st_d.cfg.fall  = wdata;
        if (wr.mask)  st_d.cfg.mask  = wdata;
        if (wr.itype) st_d.cfg.itype = wdata;
        if (wr.pol)   st_d.cfg.pol   = wdata;
        if (wr.wmask) st_d.cfg.wmask = wdata;
        st_d.src  = (st_q.src  & ~clr_src)  | evt;
        st_d.wsrc = (st_q.wsrc & ~clr_wsrc) | (evt & st_q.cfg.wmask);
        st_d.prev = pin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg  = st_q.cfg;
    assign src  = st_q.src;
    assign wsrc = st_q.wsrc;
    assign irq  = |(st_q.src & st_q.cfg.mask);
    assign wake = |st_q.wsrc;

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.src & $past(evt)) == $past(evt)));                      // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.src & $past(clr_src & ~evt)) == '0));                   // R7
    AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.src) & ~$past(clr_src) & ~st_q.src) == '0));      // R11
    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st_q.wsrc & ~$past(st_q.wsrc)) & ~$past(st_q.cfg.wmask)) == '0)); // R10
    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((~st_q.cfg.itype & ~(pin ^ st_q.prev) & evt) == '0));                  // R3
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.mask == '0) |-> !irq);                                        // R9

endmodule

// File: rtl/gpio_irq_wake.sv
module gpio_irq_wake
    import gpio_irq_pkg::*;
#(
    parameter int                NUM_PINS   = 64,
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] RISE_BASE  = 12'h064,
    parameter logic [ADDR_W-1:0] FALL_BASE  = 12'h07C,
    parameter logic [ADDR_W-1:0] MASK_BASE  = 12'h0AC,
    parameter logic [ADDR_W-1:0] SRC_BASE   = 12'h0C4,
    parameter logic [ADDR_W-1:0] TYPE_BASE  = 12'h300,
    parameter logic [ADDR_W-1:0] POL_BASE   = 12'h318,
    parameter logic [ADDR_W-1:0] WMASK_BASE = 12'h400,
    parameter logic [ADDR_W-1:0] WSRC_BASE  = 12'h418
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                irq_out,
    output logic                wake_out
);

    localparam int NBANK = NUM_PINS / BANK_W;

    bank_cfg_t         bcfg  [NBANK];
    logic [BANK_W-1:0] bsrc  [NBANK];
    logic [BANK_W-1:0] bwsrc [NBANK];
    logic [NBANK-1:0]  birq;
    logic [NBANK-1:0]  bwake;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(4 * b);
        bank_wr_t wr_w;

        always_comb begin
            wr_w       = '0;
            wr_w.rise  = reg_we && (reg_addr == RISE_BASE  + OFS);
            wr_w.fall  = reg_we && (reg_addr == FALL_BASE  + OFS);
            wr_w.mask  = reg_we && (reg_addr == MASK_BASE  + OFS);
            wr_w.src   = reg_we && (reg_addr == SRC_BASE   + OFS);
            wr_w.itype = reg_we && (reg_addr == TYPE_BASE  + OFS);
            wr_w.pol   = reg_we && (reg_addr == POL_BASE   + OFS);
            wr_w.wmask = reg_we && (reg_addr == WMASK_BASE + OFS);
            wr_w.wsrc  = reg_we && (reg_addr == WSRC_BASE  + OFS);
        end

        gpio_irq_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[b*BANK_W +: BANK_W]),
            .wr    (wr_w),
            .wdata (reg_wdata),
            .cfg   (bcfg[b]),
            .src   (bsrc[b]),
            .wsrc  (bwsrc[b]),
            .irq   (birq[b]),
            .wake  (bwake[b])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (reg_addr == RISE_BASE  + ADDR_W'(4*b)) reg_rdata = bcfg[b].rise;
            if (reg_addr == FALL_BASE  + ADDR_W'(4*b)) reg_rdata = bcfg[b].fall;
            if (reg_addr == MASK_BASE  + ADDR_W'(4*b)) reg_rdata = bcfg[b].mask;
            if (reg_addr == SRC_BASE   + ADDR_W'(4*b)) reg_rdata = bsrc[b];
            if (reg_addr == TYPE_BASE  + ADDR_W'(4*b)) reg_rdata = bcfg[b].itype;
            if (reg_addr == POL_BASE   + ADDR_W'(4*b)) reg_rdata = bcfg[b].pol;
            if (reg_addr == WMASK_BASE + ADDR_W'(4*b)) reg_rdata = bcfg[b].wmask;
            if (reg_addr == WSRC_BASE  + ADDR_W'(4*b)) reg_rdata = bwsrc[b];
        end
    end

    assign irq_out  = |birq;
    assign wake_out = |bwake;

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_out && !wake_out));                              // R1

endmodule

// File: tb/tb_gpio_irq_wake.sv
module tb_gpio_irq_wake;

    localparam int A_RISE = 'h064, A_FALL = 'h07C, A_MASK = 'h0AC, A_SRC = 'h0C4;
    localparam int A_TYPE = 'h300, A_POL = 'h318, A_WMASK = 'h400, A_WSRC = 'h418;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] pins = '0;
    logic        reg_we = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out, wake_out;
    int          errors = 0, checks = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    gpio_irq_wake dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    // {type, pol, rise, fall, pin_before, pin_after, expected}
    localparam logic [6:0] VEC [11] = '{
        7'b0_0_1_0_0_1_1,   // R3 rising seen
        7'b0_0_1_0_1_0_0,   // R3 falling ignored by rise-only
        7'b0_0_0_1_1_0_1,   // R4 falling seen
        7'b0_0_0_1_0_1_0,   // R4 rising ignored by fall-only
        7'b0_0_1_1_0_1_1,   // R4 both, up
        7'b0_0_1_1_1_0_1,   // R4 both, down
        7'b1_0_0_0_1_1_1,   // R5 high active, high
        7'b1_0_0_0_0_0_0,   // R5 high active, low
        7'b1_1_0_0_0_0_1,   // R5 low active, low
        7'b1_1_0_0_1_1_0,   // R5 low active, high
        7'b0_0_0_0_0_1_0    // R3 no enable
    };

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_we = 1; reg_addr = 12'(a); reg_wdata = d;
        tick();
        reg_we = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 12'(a);
        #1 d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        foreach (VEC[i]) ;
        for (int b = 0; b < 2; b++) begin
            wr(A_RISE + 4*b, 0); wr(A_FALL + 4*b, 0); wr(A_MASK + 4*b, 0);
            wr(A_TYPE + 4*b, 0); wr(A_POL + 4*b, 0); wr(A_WMASK + 4*b, 0);
            wr(A_SRC + 4*b, '1); wr(A_WSRC + 4*b, '1);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1 reset state
        chk("R1 irq_out", 32'(irq_out), 0);
        chk("R1 wake_out", 32'(wake_out), 0);
        for (int b = 0; b < 2; b++) begin
            foreach (VEC[i]) ;
            rd(A_RISE + 4*b, d);  chk("R1 rise", d, 0);
            rd(A_FALL + 4*b, d);  chk("R1 fall", d, 0);
            rd(A_MASK + 4*b, d);  chk("R1 mask", d, 0);
            rd(A_SRC + 4*b, d);   chk("R1 src", d, 0);
            rd(A_TYPE + 4*b, d);  chk("R1 type", d, 0);
            rd(A_POL + 4*b, d);   chk("R1 pol", d, 0);
            rd(A_WMASK + 4*b, d); chk("R1 wmask", d, 0);
            rd(A_WSRC + 4*b, d);  chk("R1 wsrc", d, 0);
        end

        // R2 register decode and bank stride
        wr(A_RISE + 4, 32'hA5A5_0001); wr(A_FALL + 4, 32'h5A5A_0002);
        wr(A_MASK + 4, 32'h1234_0003); wr(A_WMASK + 4, 32'h0F0F_0004);
        wr(A_POL + 4, 32'h0000_00F0);
        rd(A_RISE + 4, d);  chk("R2 rise bank1", d, 32'hA5A5_0001);
        rd(A_FALL + 4, d);  chk("R2 fall bank1", d, 32'h5A5A_0002);
        rd(A_MASK + 4, d);  chk("R2 mask bank1", d, 32'h1234_0003);
        rd(A_WMASK + 4, d); chk("R2 wmask bank1", d, 32'h0F0F_0004);
        rd(A_POL + 4, d);   chk("R2 pol bank1", d, 32'h0000_00F0);
        rd(A_RISE, d);      chk("R2 rise bank0 untouched", d, 0);
        rd(12'h008, d);     chk("R2 unmapped", d, 0);
        clear_all();

        // Vector table on bank 0 pin 5
        foreach (VEC[i]) begin
            pins[5] = VEC[i][2];
            wr(A_TYPE, 32'(VEC[i][6]) << 5);
            wr(A_POL,  32'(VEC[i][5]) << 5);
            wr(A_RISE, 32'(VEC[i][4]) << 5);
            wr(A_FALL, 32'(VEC[i][3]) << 5);
            tick();
            wr(A_SRC, 32'h20);
            pins[5] = VEC[i][1];
            tick();
            rd(A_SRC, d);
            chk($sformatf("R3/R4/R5 vector %0d", i), 32'(d[5]), 32'(VEC[i][0]));
        end
        pins = '0;
        clear_all();

        // R9 masking and cross-bank aggregation, pin 40 = bank1 bit 8
        wr(A_RISE + 4, 32'h100);
        pins[40] = 1; tick();
        chk("R9 masked source gives no irq", 32'(irq_out), 0);
        rd(A_SRC + 4, d); chk("R3 bank1 source set", d, 32'h100);
        wr(A_MASK + 4, 32'h100);
        chk("R9 enabled source drives irq", 32'(irq_out), 1);
        pins[40] = 0; tick();
        rd(A_SRC + 4, d); chk("R11 source sticky after pin idles", d, 32'h100);
        wr(A_SRC + 4, 32'h0);
        rd(A_SRC + 4, d); chk("R7 zero write keeps bit", d, 32'h100);
        wr(A_SRC + 4, 32'h100);
        rd(A_SRC + 4, d); chk("R7 one write clears", d, 0);
        chk("R9 irq drops after clear", 32'(irq_out), 0);
        clear_all();

        // R8 event and clear in the same cycle
        wr(A_RISE, 32'h20);
        tick();
        pins[5] = 1; reg_we = 1; reg_addr = 12'(A_SRC); reg_wdata = 32'h20;
        tick();
        reg_we = 0;
        rd(A_SRC, d); chk("R8 event beats clear", d, 32'h20);
        pins = '0;
        clear_all();

        // R6 level source re-asserts while active
        pins[5] = 1;
        wr(A_TYPE, 32'h20);
        wr(A_SRC, 32'h20);
        rd(A_SRC, d); chk("R6 level re-set after clear", d, 32'h20);
        pins[5] = 0; tick();
        wr(A_SRC, 32'h20);
        rd(A_SRC, d); chk("R6 clear holds once inactive", d, 0);
        pins = '0;
        clear_all();

        // R10 wake path
        wr(A_WMASK, 32'h80);
        wr(A_RISE, 32'h280);
        pins[7] = 1; pins[9] = 1; tick();
        rd(A_WSRC, d); chk("R10 wake only where enabled", d, 32'h80);
        chk("R10 wake_out high", 32'(wake_out), 1);
        rd(A_SRC, d); chk("R10 sources still set", d, 32'h280);
        wr(A_WSRC, 32'h80);
        rd(A_WSRC, d); chk("R10 wake cleared", d, 0);
        chk("R10 wake_out low", 32'(wake_out), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule